// File: doc/BRIEF.md
# Debug Signal Concentrator

This block gathers a chosen group of internal debug signals and places them on a smaller set of output pins that feed an embedded programmable logic region. Software writes a select mask with one bit per input. The concentrator then packs every selected input onto the lowest outputs, in order of rising input number. All downstream pins are equivalent, so the consumer does not pick which pin a signal lands on. Instead, a side-band index on each output tells the consumer which input that pin carries.

There are `N_IN` inputs and `M_OUT` outputs, with `M_OUT <= N_IN`. Any legal selection of up to `M_OUT` inputs always routes completely. When more than `M_OUT` inputs are selected, an overflow flag rises and only the lowest-numbered `M_OUT` of them are carried. An optional chain of `PIPE` register stages lets the fabric span long on-die distances. Data, valid bits, indices and the flag all travel through the same stages.

Top module: `dbg_concentrator`

## Requirements
- R1: With k selected inputs and k <= M_OUT, the selected inputs appear on outputs 0 to k-1 in rising input-number order, and all of them are routed whatever the subset is.
- R2: Outputs k to M_OUT-1 are not in use. They drive data 0, valid 0 and index 0. The valid bits always form a contiguous run starting at bit 0.
- R3: The index field of output j sits at bits [j*IW +: IW] of `out_src`, where IW = clog2(N_IN). It holds the input number that output j carries. Among the valid outputs, the indices strictly increase.
- R4: `sel_ovf` is 1 exactly when more than M_OUT mask bits are set. In that case all outputs are valid and carry the M_OUT lowest-numbered selected inputs.
- R5: `cfg_mask` is captured only on a clock edge where `cfg_we` is 1. While `cfg_we` is 0, changes on `cfg_mask` have no effect on the outputs.
- R6: Each output sample reflects one mask and one input sample, with a latency of exactly PIPE cycles. With PIPE = 0 the path is combinational from the registered mask. A new mask therefore reaches the outputs whole, PIPE cycles after the edge that follows the write.
- R7: While `rst` is high, the mask clears. Once the pipeline has been reset, all data, valid, index and flag outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Select mask write enable |
| cfg_mask | input | N_IN | New select mask, bit i selects input i |
| sig_in | input | N_IN | Debug signals to observe |
| out_data | output | M_OUT | Concentrated signals |
| out_vld | output | M_OUT | Per-output valid bits |
| out_src | output | M_OUT*IW | Per-output source input number |
| sel_ovf | output | 1 | More than M_OUT inputs selected |

## Verification
The mask patterns cover:
- an empty mask;
- single bits at both ends of the input range;
- exactly M_OUT bits, which separates full packing from off-by-one slot use;
- M_OUT+1 bits and an all-ones mask, which show whether overflow keeps the lowest inputs or the highest;
- bits only in the top half, which catches a scan direction error in the index side-band.

Random masks are rewritten while the inputs toggle every cycle. This reveals any cycle where the mapping and the data come from different samples. A directed pass changes `cfg_mask` with the write enable low, and a single-edge test counts the pipeline latency.

// File: rtl/dbg_concentrator.sv
module dbg_concentrator #(
  parameter int N_IN  = 16,
  parameter int M_OUT = 4,
  parameter int PIPE  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [N_IN-1:0]       cfg_mask,
  input  logic [N_IN-1:0]       sig_in,
  output logic [M_OUT-1:0]      out_data,
  output logic [M_OUT-1:0]      out_vld,
  output logic [M_OUT*((N_IN>1)?$clog2(N_IN):1)-1:0] out_src,
  output logic                  sel_ovf
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int CW = $clog2(N_IN + 1);
  localparam int SW = 2*M_OUT + M_OUT*IW + 1;

  logic [N_IN-1:0]     mask_q;
  logic [M_OUT-1:0]    c_data, c_vld;
  logic [M_OUT*IW-1:0] c_src;
  logic                c_ovf;
  logic [CW-1:0]       rank;
  logic [SW-1:0]       stg_in, stg_out;

  always_ff @(posedge clk)
    if (rst)         mask_q <= '0;
    else if (cfg_we) mask_q <= cfg_mask;

  always_comb begin
    c_data = '0;
    c_vld  = '0;
    c_src  = '0;
    rank   = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (mask_q[i]) begin
        for (int j = 0; j < M_OUT; j++) begin
          if (rank == CW'(j)) begin
            c_data[j]           = sig_in[i];
            c_vld[j]            = 1'b1;
            c_src[j*IW +: IW]   = IW'(i);
          end
        end
        rank = rank + 1'b1;
      end
    end
    c_ovf = (rank > CW'(M_OUT));
  end

  assign stg_in = {c_ovf, c_src, c_vld, c_data};

  generate
    if (PIPE == 0) begin : g_flat
      assign stg_out = stg_in;
    end else begin : g_pipe
      logic [SW-1:0] pr [PIPE];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < PIPE; s++) pr[s] <= '0;
        end else begin
          pr[0] <= stg_in;
          for (int s = 1; s < PIPE; s++) pr[s] <= pr[s-1];
        end
      end
      assign stg_out = pr[PIPE-1];
    end
  endgenerate

  assign {sel_ovf, out_src, out_vld, out_data} = stg_out;
endmodule

// File: rtl/dbg_concentrator_chk.sv
module dbg_concentrator_chk #(
  parameter int N_IN  = 16,
  parameter int M_OUT = 4,
  parameter int IW    = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [M_OUT-1:0]      out_data,
  input logic [M_OUT-1:0]      out_vld,
  input logic [M_OUT*IW-1:0]   out_src,
  input logic                  sel_ovf
);
  p_contig_vld_r2: assert property (@(posedge clk) disable iff (rst)
    (out_vld & (out_vld + 1'b1)) == '0);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (out_data & ~out_vld) == '0);

  p_ovf_full_r4: assert property (@(posedge clk) disable iff (rst)
    sel_ovf |-> (&out_vld));

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (out_vld == '0 && out_data == '0 && sel_ovf == 1'b0));

  generate
    for (genvar j = 0; j < M_OUT; j++) begin : g_slot
      p_idle_src_r2: assert property (@(posedge clk) disable iff (rst)
        !out_vld[j] |-> (out_src[j*IW +: IW] == '0));
      if (j > 0) begin : g_ord
        p_src_order_r3: assert property (@(posedge clk) disable iff (rst)
          out_vld[j] |-> (out_src[j*IW +: IW] > out_src[(j-1)*IW +: IW]));
        p_pack_r1: assert property (@(posedge clk) disable iff (rst)
          out_vld[j] |-> out_vld[j-1]);
      end
    end
  endgenerate
endmodule

bind dbg_concentrator dbg_concentrator_chk #(
  .N_IN(N_IN), .M_OUT(M_OUT), .IW(IW)
) u_chk (
  .clk(clk), .rst(rst), .out_data(out_data), .out_vld(out_vld),
  .out_src(out_src), .sel_ovf(sel_ovf)
);

// File: tb/tb_dbg_concentrator.sv
`timescale 1ns/1ps
module tb_dbg_concentrator;
  localparam int N  = 16;
  localparam int M  = 4;
  localparam int P  = 2;
  localparam int IW = $clog2(N);

  typedef struct packed {
    logic            o;
    logic [M*IW-1:0] s;
    logic [M-1:0]    v;
    logic [M-1:0]    d;
  } rec_t;

  logic clk = 0, rst = 1, cfg_we = 0;
  logic [N-1:0] cfg_mask = '0, sig_in = '0;
  logic [M-1:0] out_data, out_vld;
  logic [M*IW-1:0] out_src;
  logic sel_ovf;

  int total = 0, bad = 0;
  bit chk_en = 0, done = 0;

  always #2 clk = ~clk;

  dbg_concentrator #(.N_IN(N), .M_OUT(M), .PIPE(P)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
    .sig_in(sig_in), .out_data(out_data), .out_vld(out_vld),
    .out_src(out_src), .sel_ovf(sel_ovf));

  function automatic rec_t pack_ref(logic [N-1:0] din, logic [N-1:0] msk);
    rec_t r = '0;
    int k = 0;
    for (int i = 0; i < N; i++) begin
      if (msk[i]) begin
        if (k < M) begin
          r.d[k] = din[i];
          r.v[k] = 1'b1;
          r.s[k*IW +: IW] = IW'(i);
        end
        k++;
      end
    end
    r.o = (k > M);
    return r;
  endfunction

  logic [N-1:0] mask_m = '0;
  rec_t q[$];

  always @(posedge clk) begin
    if (rst) begin
      mask_m = '0;
      q.delete();
      for (int s = 0; s < P; s++) q.push_back('0);
    end else begin
      if (P > 0) begin
        q.push_back(pack_ref(sig_in, mask_m));
        void'(q.pop_front());
      end
      if (cfg_we) mask_m = cfg_mask;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !rst) begin
      rec_t e;
      e = (P == 0) ? pack_ref(sig_in, mask_m) : q[0];
      check("R1 data", 64'(out_data), 64'(e.d));
      check("R2 valid", 64'(out_vld), 64'(e.v));
      check("R3 source index", 64'(out_src), 64'(e.s));
      check("R4 overflow", 64'(sel_ovf), 64'(e.o));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_mask(logic [N-1:0] m);
    cfg_mask = m; cfg_we = 1; step(); cfg_we = 0;
  endtask

  task automatic run_mask(logic [N-1:0] m, int cyc);
    write_mask(m);
    for (int c = 0; c < cyc; c++) begin
      sig_in = N'($urandom);
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    sig_in = '1;
    cfg_mask = '1;
    repeat (P + 3) step();
    @(negedge clk);
    check("R7 reset valid", 64'(out_vld), 64'(0));
    check("R7 reset data", 64'(out_data), 64'(0));
    check("R7 reset index", 64'(out_src), 64'(0));
    check("R7 reset flag", 64'(sel_ovf), 64'(0));
    step();
    rst = 0;
    chk_en = 1;
    repeat (P + 2) step();
    check("R7 mask cleared", 64'(out_vld), 64'(0));

    run_mask('0, 10);
    run_mask(N'(1), 10);
    run_mask(N'(1) << (N-1), 10);
    run_mask(N'(16'h0F00), 10);
    run_mask(N'(16'h8421), 10);
    run_mask(N'(16'h1F00), 10);
    run_mask('1, 10);
    run_mask(N'(16'hF000), 10);
    run_mask(N'(16'h0005), 10);

    // R5: mask input ignored without write enable
    sig_in = '1;
    cfg_mask = '1;
    repeat (P + 4) step();
    check("R5 no write valid", 64'(out_vld), 64'(4'b0011));
    check("R5 no write flag", 64'(sel_ovf), 64'(0));

    // R6: latency from input edge to output edge
    write_mask(N'(1));
    sig_in = '0;
    repeat (P + 3) step();
    sig_in = N'(1);
    begin
      int n = 0;
      @(negedge clk);
      while (out_data[0] !== 1'b1 && n < 20) begin
        step(); n++;
        @(negedge clk);
      end
      check("R6 latency", 64'(n), 64'(P));
    end
    step();

    for (int t = 0; t < 400; t++) begin
      if (($urandom % 4) == 0) begin
        cfg_mask = N'($urandom) & N'($urandom);
        cfg_we = 1;
      end else begin
        cfg_mask = N'($urandom);
        cfg_we = 0;
      end
      sig_in = N'($urandom);
      step();
    end
    cfg_we = 0;
    repeat (P + 2) step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule